// File: doc/BRIEF.md
# Flash Block Write-Protection Gate

This block sits between the command decoder of a dual-bank boot-block flash array and its program/erase engine. For every program or erase request it works out which erase block the address falls in, weighs three layered protection sources against it, and answers with a one-cycle grant or reject pulse. It also reports the bank the target lies in. The array is built from 63 large main blocks and 8 small parameter blocks, split into two equal banks. A strap input places the parameter blocks either at the top or at the bottom of the address space.

The protection sources are applied in a fixed order. A one-time extended-block lock refuses all requests to the extra extended block once it has been set. The write-protect pin, while low, guards the two outermost boot blocks, and nothing overrides it. A per-block protection register guards any block, and the reset pin's elevated "temporary unprotect" level lifts this last layer. The gate also lets only one bank be in program/erase at a time. A granted request marks its bank busy until the engine signals completion. While that bank is busy, requests to the other bank are refused and requests to the same bank are still accepted.

The request address is the upper part of a word address, the bits above the 4 Kword parameter-block boundary. Its top bit selects the bank.

Top module: `wpg_gate`

## Requirements
- R1: With `topBoot`=1, sector s = `reqBlkAddr[8:3]` below 63 maps to block s. Sector 63 splits into parameter blocks 63+`reqBlkAddr[2:0]`, and blocks 69 and 70 are the two outermost boot blocks. `reqBank` reports `reqBlkAddr[8]` of the request alongside its result.
- R2: With `topBoot`=0, sector 0 splits into parameter blocks 0..7 selected by `reqBlkAddr[2:0]`, and blocks 0 and 1 are the two outermost boot blocks. Sector s ≥ 1 maps to block s+7.
- R3: Each request (`reqValid`=1 for one cycle) produces exactly one of `grant` or `reject`, high for one cycle, in the cycle after the request edge. Neither is ever raised without a request.
- R4: A write (`protWe`=1) stores `protVal` as the protection bit of block `protIdx`. A non-extended request to a block whose bit is 1 is rejected while `tempUnprot`=0.
- R5: While `tempUnprot`=1, a block protected only by its per-block bit is granted.
- R6: While `wpN`=0, requests to the two outermost boot blocks are rejected, whatever their protection bit and whatever `tempUnprot` is.
- R7: While `wpN`=1, the two outermost boot blocks follow their per-block bit like any other block.
- R8: `extLockSet` sets a sticky extended-block lock. Once it is set, every request with `reqExt`=1 is rejected, `tempUnprot` does not lift it, and `rstN` does not clear it. Only `porN` clears it.
- R9: A grant makes the target bank busy (`busy`=1, `activeBank`=bank) until `opDone`. While busy, a request to the other bank is rejected and a request to the same bank is granted.
- R10: `rstN`=0 or `porN`=0 clears every per-block protection bit, `busy`, `grant` and `reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low; also clears the extended-block lock |
| rstN | input | 1 | Reset pin at its low level, active low |
| topBoot | input | 1 | Strap: 1 = parameter blocks at the top, 0 = at the bottom |
| wpN | input | 1 | Write-protect pin level; 0 guards the two outermost boot blocks |
| tempUnprot | input | 1 | Reset pin at its elevated temporary-unprotect level |
| protWe | input | 1 | Protection register write strobe |
| protIdx | input | 7 | Block index to write |
| protVal | input | 1 | Protection bit value to write |
| extLockSet | input | 1 | Sets the one-time extended-block lock |
| reqValid | input | 1 | Program/erase request strobe |
| reqExt | input | 1 | Request targets the extended block |
| reqBlkAddr | input | 9 | Word address bits 20..12 of the request |
| opDone | input | 1 | Active program/erase has finished |
| grant | output | 1 | One-cycle pulse: request accepted |
| reject | output | 1 | One-cycle pulse: request refused |
| reqBank | output | 1 | Bank of the request answered this cycle |
| busy | output | 1 | A bank is in program/erase |
| activeBank | output | 1 | Bank currently in program/erase |

## Verification
Every result of the gate sits in a register one edge past the request. `grant`, `reject` and `reqBank` appear in the cycle after the edge that saw `reqValid`, and `busy`/`activeBank` change on that same edge. `opDone` clears `busy` on the next edge. The bench drives all inputs on the falling edge and samples the outputs on the following falling edge, which is exactly one rising edge later. After each granted table vector it spends one more cycle on `opDone`, so that bank exclusivity never leaks into the protection vectors. The directed bank tests leave `busy` set on purpose.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  // Strobes issued by the control to the datapath output stage.
  typedef struct packed {
    logic grant;
    logic reject;
    logic bank;
  } wpgStrobe_t;

endpackage

// File: rtl/wpg_blockmap.sv
module wpg_blockmap #(
  parameter int SECT_W     = 6,
  parameter int SUB_W      = 3,
  parameter int BOOT_GUARD = 2,
  parameter int IDX_W      = 7
) (
  input  logic [SECT_W+SUB_W-1:0] blkAddr,
  input  logic                    topBoot,
  output logic [IDX_W-1:0]        blkIdx,
  output logic                    outerHit,
  output logic                    bankSel
);

  localparam int PARAMS = 1 << SUB_W;
  localparam int MAINS  = (1 << SECT_W) - 1;
  localparam logic [SECT_W-1:0] LAST_SECT = '1;
  localparam logic [SUB_W-1:0]  GUARD_HI  = SUB_W'(PARAMS - BOOT_GUARD);
  localparam logic [SUB_W-1:0]  GUARD_LO  = SUB_W'(BOOT_GUARD);

  logic [SECT_W-1:0] sector;
  logic [SUB_W-1:0]  sub;

  assign sector  = blkAddr[SECT_W+SUB_W-1:SUB_W];
  assign sub     = blkAddr[SUB_W-1:0];
  assign bankSel = blkAddr[SECT_W+SUB_W-1];

  always_comb begin
    blkIdx   = IDX_W'(sector);
    outerHit = 1'b0;
    if (topBoot) begin
      if (sector == LAST_SECT) begin
        blkIdx   = IDX_W'(MAINS) + IDX_W'(sub);
        outerHit = (sub >= GUARD_HI);
      end
    end else begin
      if (sector == '0) begin
        blkIdx   = IDX_W'(sub);
        outerHit = (sub < GUARD_LO);
      end else begin
        blkIdx = IDX_W'(sector) + IDX_W'(PARAMS - 1);
      end
    end
  end

endmodule

// File: rtl/wpg_protreg.sv
module wpg_protreg #(
  parameter int NBLK  = 71,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstAll,
  input  logic             protWe,
  input  logic [IDX_W-1:0] protIdx,
  input  logic             protVal,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdBit
);

  logic [NBLK-1:0] protVec;

  for (genvar b = 0; b < NBLK; b++) begin : g_bit
    logic bitQ;
    always_ff @(posedge clk or negedge rstAll) begin
      if (!rstAll)                               bitQ <= 1'b0;
      else if (protWe && protIdx == IDX_W'(b))   bitQ <= protVal;
    end
    assign protVec[b] = bitQ;
  end

  assign rdBit = protVec[rdIdx];

endmodule

// File: rtl/wpg_datapath.sv
module wpg_datapath
  import wpg_pkg::*;
#(
  parameter int SECT_W     = 6,
  parameter int SUB_W      = 3,
  parameter int BOOT_GUARD = 2,
  parameter int NBLK       = 71,
  parameter int IDX_W      = 7
) (
  input  logic                    clk,
  input  logic                    rstAll,
  input  logic                    porN,
  input  logic                    topBoot,
  input  logic                    wpN,
  input  logic                    tempUnprot,
  input  logic                    protWe,
  input  logic [IDX_W-1:0]        protIdx,
  input  logic                    protVal,
  input  logic                    extLockSet,
  input  logic                    reqExt,
  input  logic [SECT_W+SUB_W-1:0] reqBlkAddr,
  input  wpgStrobe_t              stb,
  output logic                    protDeny,
  output logic                    bankSel,
  output logic                    outerHit,
  output logic                    extLocked,
  output logic                    grant,
  output logic                    reject,
  output logic                    reqBank
);

  logic [IDX_W-1:0] blkIdx;
  logic             blkProt;
  logic             denyExt, denyWp, denyBit;

  wpg_blockmap #(
    .SECT_W(SECT_W), .SUB_W(SUB_W), .BOOT_GUARD(BOOT_GUARD), .IDX_W(IDX_W)
  ) u_map (
    .blkAddr(reqBlkAddr), .topBoot(topBoot),
    .blkIdx(blkIdx), .outerHit(outerHit), .bankSel(bankSel)
  );

  wpg_protreg #(.NBLK(NBLK), .IDX_W(IDX_W)) u_prot (
    .clk(clk), .rstAll(rstAll), .protWe(protWe), .protIdx(protIdx),
    .protVal(protVal), .rdIdx(blkIdx), .rdBit(blkProt)
  );

  // Sticky extended-block lock: only power-on clears it.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)           extLocked <= 1'b0;
    else if (extLockSet) extLocked <= 1'b1;
  end

  // Layered verdict: extended lock, then write-protect pin, then per-block bit.
  always_comb begin
    denyExt  = reqExt & extLocked;
    denyWp   = ~reqExt & outerHit & ~wpN;
    denyBit  = ~reqExt & blkProt & ~tempUnprot;
    protDeny = denyExt | denyWp | denyBit;
  end

  always_ff @(posedge clk or negedge rstAll) begin
    if (!rstAll) begin
      grant   <= 1'b0;
      reject  <= 1'b0;
      reqBank <= 1'b0;
    end else begin
      grant  <= stb.grant;
      reject <= stb.reject;
      if (stb.grant || stb.reject) reqBank <= stb.bank;
    end
  end

endmodule

// File: rtl/wpg_control.sv
module wpg_control
  import wpg_pkg::*;
(
  input  logic       clk,
  input  logic       rstAll,
  input  logic       reqValid,
  input  logic       protDeny,
  input  logic       bankSel,
  input  logic       opDone,
  output wpgStrobe_t stb,
  output logic       busy,
  output logic       activeBank
);

  logic conflict;

  always_comb begin
    conflict   = busy & (bankSel != activeBank);
    stb.grant  = reqValid & ~protDeny & ~conflict;
    stb.reject = reqValid & ~stb.grant;
    stb.bank   = bankSel;
  end

  always_ff @(posedge clk or negedge rstAll) begin
    if (!rstAll) begin
      busy       <= 1'b0;
      activeBank <= 1'b0;
    end else if (stb.grant) begin
      busy       <= 1'b1;
      activeBank <= bankSel;
    end else if (opDone) begin
      busy       <= 1'b0;
    end
  end

endmodule

// File: rtl/wpg_gate.sv
module wpg_gate
  import wpg_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int MAIN_SHIFT  = 15,
  parameter int PARAM_SHIFT = 12,
  parameter int BOOT_GUARD  = 2,
  localparam int SECT_W = ADDR_W - MAIN_SHIFT,
  localparam int SUB_W  = MAIN_SHIFT - PARAM_SHIFT,
  localparam int NBLK   = (1 << SECT_W) - 1 + (1 << SUB_W),
  localparam int IDX_W  = $clog2(NBLK),
  localparam int BA_W   = ADDR_W - PARAM_SHIFT
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  logic             topBoot,
  input  logic             wpN,
  input  logic             tempUnprot,
  input  logic             protWe,
  input  logic [IDX_W-1:0] protIdx,
  input  logic             protVal,
  input  logic             extLockSet,
  input  logic             reqValid,
  input  logic             reqExt,
  input  logic [BA_W-1:0]  reqBlkAddr,
  input  logic             opDone,
  output logic             grant,
  output logic             reject,
  output logic             reqBank,
  output logic             busy,
  output logic             activeBank
);

  logic       rstAll;
  logic       protDeny, bankSel, outerHit, extLocked;
  wpgStrobe_t stb;

  assign rstAll = rstN & porN;

  wpg_datapath #(
    .SECT_W(SECT_W), .SUB_W(SUB_W), .BOOT_GUARD(BOOT_GUARD),
    .NBLK(NBLK), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstAll(rstAll), .porN(porN), .topBoot(topBoot), .wpN(wpN),
    .tempUnprot(tempUnprot), .protWe(protWe), .protIdx(protIdx),
    .protVal(protVal), .extLockSet(extLockSet), .reqExt(reqExt),
    .reqBlkAddr(reqBlkAddr), .stb(stb), .protDeny(protDeny),
    .bankSel(bankSel), .outerHit(outerHit), .extLocked(extLocked),
    .grant(grant), .reject(reject), .reqBank(reqBank)
  );

  wpg_control u_ctl (
    .clk(clk), .rstAll(rstAll), .reqValid(reqValid), .protDeny(protDeny),
    .bankSel(bankSel), .opDone(opDone), .stb(stb), .busy(busy),
    .activeBank(activeBank)
  );

endmodule

// File: rtl/wpg_checker.sv
module wpg_checker (
  input logic clk,
  input logic rstAll,
  input logic porN,
  input logic reqValid,
  input logic reqExt,
  input logic reqMsb,
  input logic wpN,
  input logic outerHit,
  input logic extLocked,
  input logic grant,
  input logic reject,
  input logic busy,
  input logic activeBank
);

  // R3
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstAll)
    $onehot0({grant, reject}));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstAll)
    !reqValid |=> (!grant && !reject));

  // R3
  answer_due_chk: assert property (@(posedge clk) disable iff (!rstAll)
    reqValid |=> (grant || reject));

  // R6
  wp_guard_chk: assert property (@(posedge clk) disable iff (!rstAll)
    (reqValid && !reqExt && outerHit && !wpN) |=> reject);

  // R8
  ext_sticky_chk: assert property (@(posedge clk) disable iff (!porN)
    extLocked |=> extLocked);

  // R8
  ext_deny_chk: assert property (@(posedge clk) disable iff (!rstAll)
    (reqValid && reqExt && extLocked) |=> reject);

  // R9
  other_bank_chk: assert property (@(posedge clk) disable iff (!rstAll)
    (busy && reqValid && (reqMsb != activeBank)) |=> reject);

  // R9
  grant_busy_chk: assert property (@(posedge clk) disable iff (!rstAll)
    grant |-> busy);

endmodule

bind wpg_gate wpg_checker i_wpgChk (
  .clk(clk), .rstAll(rstAll), .porN(porN), .reqValid(reqValid),
  .reqExt(reqExt), .reqMsb(reqBlkAddr[BA_W-1]), .wpN(wpN),
  .outerHit(outerHit), .extLocked(extLocked), .grant(grant),
  .reject(reject), .busy(busy), .activeBank(activeBank)
);

// File: tb/test_wpg_gate.sv
module test_wpg_gate;

  logic       clk = 1'b0;
  logic       porN, rstN, topBoot, wpN, tempUnprot;
  logic       protWe, protVal, extLockSet, reqValid, reqExt, opDone;
  logic [6:0] protIdx;
  logic [8:0] reqBlkAddr;
  logic       grant, reject, reqBank, busy, activeBank;

  int testsRun = 0;
  int testsFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wpg_gate i_wpg_gate (
    .clk(clk), .porN(porN), .rstN(rstN), .topBoot(topBoot), .wpN(wpN),
    .tempUnprot(tempUnprot), .protWe(protWe), .protIdx(protIdx),
    .protVal(protVal), .extLockSet(extLockSet), .reqValid(reqValid),
    .reqExt(reqExt), .reqBlkAddr(reqBlkAddr), .opDone(opDone),
    .grant(grant), .reject(reject), .reqBank(reqBank), .busy(busy),
    .activeBank(activeBank)
  );

  // {topBoot, wpN, tempUnprot, wordAddr[20:0], expectGrant}
  localparam int NVEC = 19;
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 21'h050000, 1'b1},  // R1 top main block 10
    {1'b1, 1'b1, 1'b0, 21'h028000, 1'b0},  // R4 top block 5 bit set
    {1'b1, 1'b1, 1'b1, 21'h028000, 1'b1},  // R5 temp unprotect lifts bit
    {1'b1, 1'b0, 1'b0, 21'h1FE000, 1'b0},  // R6 top block 69 guarded
    {1'b1, 1'b1, 1'b0, 21'h1FE000, 1'b1},  // R7 block 69 bit clear
    {1'b1, 1'b0, 1'b1, 21'h1FE000, 1'b0},  // R6 pin beats temp unprotect
    {1'b1, 1'b1, 1'b0, 21'h1FF000, 1'b0},  // R7 block 70 bit set
    {1'b1, 1'b1, 1'b1, 21'h1FF000, 1'b1},  // R5 block 70 temp unprotect
    {1'b1, 1'b0, 1'b1, 21'h1FF000, 1'b0},  // R6 block 70 pin low
    {1'b1, 1'b0, 1'b0, 21'h1FD000, 1'b1},  // R1 block 68 not outermost
    {1'b0, 1'b0, 1'b0, 21'h001000, 1'b0},  // R2 bottom block 1 guarded
    {1'b0, 1'b0, 1'b0, 21'h002000, 1'b1},  // R2 bottom block 2 free
    {1'b0, 1'b1, 1'b0, 21'h000000, 1'b0},  // R2 bottom block 0 bit set
    {1'b0, 1'b1, 1'b1, 21'h000000, 1'b1},  // R5 bottom block 0
    {1'b0, 1'b1, 1'b0, 21'h005000, 1'b0},  // R2 bottom block 5 bit set
    {1'b0, 1'b1, 1'b0, 21'h068000, 1'b0},  // R2 sector 13 -> block 20
    {1'b0, 1'b1, 1'b0, 21'h070000, 1'b1},  // R2 sector 14 -> block 21
    {1'b1, 1'b0, 1'b0, 21'h001000, 1'b0},  // R1 top sector 0 -> block 0
    {1'b0, 1'b0, 1'b1, 21'h1FF000, 1'b1}   // R2 bottom sector 63 -> block 70
  };

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic writeProt(input int idx, input logic val);
    @(negedge clk);
    protWe = 1'b1; protIdx = 7'(idx); protVal = val;
    @(negedge clk);
    protWe = 1'b0;
  endtask

  task automatic finishOp();
    opDone = 1'b1;
    @(negedge clk);
    opDone = 1'b0;
  endtask

  // Drive one request; outputs are sampled one rising edge later.
  task automatic doReq(input string tag, input logic [20:0] addr,
                       input logic ext, input logic expGrant,
                       input logic autoDone);
    @(negedge clk);
    reqValid = 1'b1; reqExt = ext; reqBlkAddr = addr[20:12];
    @(negedge clk);
    reqValid = 1'b0; reqExt = 1'b0;
    check({tag, " grant"}, int'(grant), int'(expGrant));
    check({tag, " reject"}, int'(reject), int'(!expGrant));
    check({tag, " bank"}, int'(reqBank), int'(addr[20]));
    if (autoDone && grant) finishOp();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    porN = 1'b0; rstN = 1'b0; topBoot = 1'b1; wpN = 1'b1; tempUnprot = 1'b0;
    protWe = 1'b0; protIdx = '0; protVal = 1'b0; extLockSet = 1'b0;
    reqValid = 1'b0; reqExt = 1'b0; reqBlkAddr = '0; opDone = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset grant", int'(grant), 0);
    check("R10 reset reject", int'(reject), 0);
    check("R10 reset busy", int'(busy), 0);
    porN = 1'b1; rstN = 1'b1;

    // R4 load protection bits
    writeProt(0, 1'b1);
    writeProt(5, 1'b1);
    writeProt(20, 1'b1);
    writeProt(70, 1'b1);

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      topBoot = VEC[v][24]; wpN = VEC[v][23]; tempUnprot = VEC[v][22];
      doReq($sformatf("R1/R2 vec%0d", v), VEC[v][21:1], 1'b0, VEC[v][0], 1'b1);
    end

    // R3 no request, no pulse
    @(negedge clk);
    check("R3 idle grant", int'(grant), 0);
    check("R3 idle reject", int'(reject), 0);

    // R4 clearing a bit through the write port
    topBoot = 1'b1; wpN = 1'b1; tempUnprot = 1'b0;
    writeProt(5, 1'b0);
    doReq("R4 cleared bit", 21'h028000, 1'b0, 1'b1, 1'b1);
    writeProt(5, 1'b1);

    // R8 extended lock
    doReq("R8 ext unlocked", 21'h010000, 1'b1, 1'b1, 1'b1);
    @(negedge clk); extLockSet = 1'b1;
    @(negedge clk); extLockSet = 1'b0;
    doReq("R8 ext locked", 21'h010000, 1'b1, 1'b0, 1'b1);
    tempUnprot = 1'b1;
    doReq("R8 ext temp unprot", 21'h010000, 1'b1, 1'b0, 1'b1);
    tempUnprot = 1'b0;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    doReq("R8 ext after rstN", 21'h010000, 1'b1, 1'b0, 1'b1);
    // R10 reset cleared block 5 bit
    doReq("R10 bits cleared", 21'h028000, 1'b0, 1'b1, 1'b1);

    // R9 bank exclusivity
    doReq("R9 bank0 first", 21'h000000, 1'b0, 1'b1, 1'b0);
    check("R9 busy set", int'(busy), 1);
    check("R9 active bank0", int'(activeBank), 0);
    doReq("R9 other bank", 21'h100000, 1'b0, 1'b0, 1'b0);
    doReq("R9 same bank", 21'h008000, 1'b0, 1'b1, 1'b0);
    finishOp();
    check("R9 busy cleared", int'(busy), 0);
    doReq("R9 bank1 after done", 21'h100000, 1'b0, 1'b1, 1'b0);
    check("R9 active bank1", int'(activeBank), 1);
    finishOp();

    // R8 power-on clears the lock
    @(negedge clk); porN = 1'b0;
    @(negedge clk); @(negedge clk); porN = 1'b1;
    doReq("R8 ext after porN", 21'h010000, 1'b1, 1'b1, 1'b1);

    summary();
  end

endmodule